// File: doc/BRIEF.md
# Single-Precision to Signed 32-bit Integer Converter

This block turns one IEEE-754 single-precision operand into a two's-complement 32-bit integer. A start strobe launches a conversion. Exactly one cycle later the block presents the integer, a write enable for the destination register, an invalid-operation flag and an inexact flag, together with a one-cycle done pulse.

Two conversion flavours exist. The rounding flavour applies a 2-bit rounding mode taken from a control register. The truncating flavour always rounds toward zero and ignores that field. NaN and infinity operands are invalid operations. So is any operand whose rounded value falls outside the signed 32-bit range. For invalid operations, an exception-mask input chooses between two responses. When masked, the block writes the integer-indefinite pattern. When unmasked, it suppresses the write and leaves the destination as it was.

Top module: `fp32_to_int32_cvt`

## Requirements
- R1: The result, write enable and flags are registered. They appear in the cycle after the one in which `start_i` is high, and `done_o` is high for exactly that one cycle.
- R2: With `trunc_i` low, the rounding mode `rmode_i` is applied with this encoding: 2'b00 is nearest with ties to even, 2'b01 is toward minus infinity, 2'b10 is toward plus infinity, 2'b11 is toward zero.
- R3: With `trunc_i` high, the conversion rounds toward zero, whatever the value of `rmode_i`.
- R4: An operand with exponent field bits [30:23] all ones (NaN of either kind, or ±infinity) raises `invalid_o`.
- R5: A value whose rounded magnitude exceeds 0x7FFFFFFF raises `invalid_o`. The one exception is a rounded value of exactly -2^31, which converts validly to 0x80000000.
- R6: On an invalid operation with `inv_mask_i` high, `result_o` is 0x80000000, `wr_en_o` is high and `invalid_o` is high.
- R7: On an invalid operation with `inv_mask_i` low, `wr_en_o` is low, `invalid_o` is high and `result_o` keeps the value it last took.
- R8: On a valid conversion, `inexact_o` is high exactly when non-zero fraction bits were discarded. On an invalid one, `inexact_o` is low.
- R9: A zero or denormal operand converts to 0, or to -1 or +1 where the directed rounding mode demands it, and never raises `invalid_o`.
- R10: After reset, `result_o`, `wr_en_o`, `invalid_o`, `inexact_o` and `done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Launch a conversion of the current inputs |
| operand_i | input | 32 | Single-precision source operand |
| trunc_i | input | 1 | 1 selects the truncating flavour |
| rmode_i | input | 2 | Rounding mode from the control register |
| inv_mask_i | input | 1 | 1 masks the invalid-operation exception |
| result_o | output | 32 | Converted integer (updated only when written) |
| wr_en_o | output | 1 | Destination write enable, valid with done |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Inexact (precision) flag |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench sweeps every exponent with both signs, several mantissa patterns and every rounding mode and flavour. Each result is compared with a real-arithmetic model. The sweep covers the ±2^31 edge, where a design that tests the magnitude before rounding, or forgets the -2^31 exception, would either reject a legal value or accept an overflow. It also covers exact halves, which catch a nearest mode that rounds away from zero instead of to even. Denormals with directed modes catch a design that flushes them to zero without producing ±1, and NaN and infinity with both mask settings catch a write that leaks through when the exception is unmasked.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  localparam int unsigned EXP_W = 8;
  localparam int unsigned MAN_W = 23;
  localparam int unsigned INT_W = 32;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic             neg;
    logic             special;
    logic             huge;
    logic [INT_W:0]   whole;
    logic             guard;
    logic             sticky;
  } align_t;

endpackage

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
#(
  parameter int unsigned P_EXP_W = EXP_W,
  parameter int unsigned P_MAN_W = MAN_W,
  parameter int unsigned P_INT_W = INT_W
) (
  input  logic [P_EXP_W+P_MAN_W:0] op_i,
  output align_t                   al_o
);

  localparam int unsigned BIAS   = (1 << (P_EXP_W - 1)) - 1;
  localparam int unsigned POINT  = BIAS + P_MAN_W;
  localparam int unsigned TOP    = BIAS + P_INT_W - 1;
  localparam int unsigned SIG_W  = P_MAN_W + 1;
  localparam int unsigned WIDE_W = SIG_W + P_INT_W;

  localparam logic [P_EXP_W-1:0] EMAX_E  = '1;
  localparam logic [P_EXP_W-1:0] POINT_E = POINT[P_EXP_W-1:0];
  localparam logic [P_EXP_W-1:0] TOP_E   = TOP[P_EXP_W-1:0];
  localparam logic [P_EXP_W-1:0] LIMR_E  = P_INT_W[P_EXP_W-1:0];

  logic [P_EXP_W-1:0] exp_f;
  logic [P_MAN_W-1:0] frac_f;
  logic [SIG_W-1:0]   sig;
  logic [P_EXP_W-1:0] lsh;
  logic [P_EXP_W-1:0] rsh;
  logic [WIDE_W-1:0]  wide;
  logic [P_INT_W:0]   sig_ext;

  assign exp_f   = op_i[P_EXP_W+P_MAN_W-1:P_MAN_W];
  assign frac_f  = op_i[P_MAN_W-1:0];
  assign sig     = {1'b1, frac_f};
  assign lsh     = exp_f - POINT_E;
  assign rsh     = POINT_E - exp_f;
  assign wide    = {sig, {P_INT_W{1'b0}}} >> rsh;
  assign sig_ext = {{(P_INT_W + 1 - SIG_W){1'b0}}, sig};

  always_comb begin
    al_o         = '0;
    al_o.neg     = op_i[P_EXP_W+P_MAN_W];
    al_o.special = (exp_f == EMAX_E);
    al_o.huge    = (exp_f != EMAX_E) && (exp_f > TOP_E);
    if (exp_f == '0) begin
      // zero or denormal: magnitude below one half
      al_o.sticky = |frac_f;
    end else if (exp_f >= POINT_E) begin
      if (exp_f <= TOP_E) begin
        al_o.whole = sig_ext << lsh;
      end
    end else if (rsh > LIMR_E) begin
      // every significant bit lies below the guard position
      al_o.sticky = 1'b1;
    end else begin
      al_o.whole  = {{(P_INT_W + 1 - SIG_W){1'b0}}, wide[WIDE_W-1:P_INT_W]};
      al_o.guard  = wide[P_INT_W-1];
      al_o.sticky = |wide[P_INT_W-2:0];
    end
  end

endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int unsigned P_INT_W = INT_W
) (
  input  align_t           al_i,
  input  rmode_e           mode_i,
  output logic [P_INT_W:0] mag_o,
  output logic             lost_o
);

  logic inc;
  logic any_lost;

  assign any_lost = al_i.guard | al_i.sticky;

  always_comb begin
    unique case (mode_i)
      RM_NEAR: inc = al_i.guard & (al_i.sticky | al_i.whole[0]);
      RM_DOWN: inc = al_i.neg & any_lost;
      RM_UP:   inc = ~al_i.neg & any_lost;
      default: inc = 1'b0;
    endcase
  end

  assign mag_o  = al_i.whole + {{P_INT_W{1'b0}}, inc};
  assign lost_o = any_lost;

endmodule

// File: rtl/f2i_range.sv
module f2i_range
  import f2i_pkg::*;
#(
  parameter int unsigned P_INT_W = INT_W
) (
  input  logic               neg_i,
  input  logic               special_i,
  input  logic               huge_i,
  input  logic [P_INT_W:0]   mag_i,
  input  logic               lost_i,
  input  logic               mask_i,
  output logic [P_INT_W-1:0] res_o,
  output logic               write_o,
  output logic               invalid_o,
  output logic               inexact_o
);

  localparam logic [P_INT_W:0]   LIM_POS = {2'b00, {(P_INT_W - 1){1'b1}}};
  localparam logic [P_INT_W:0]   LIM_NEG = {2'b01, {(P_INT_W - 1){1'b0}}};
  localparam logic [P_INT_W-1:0] INDEF   = {1'b1, {(P_INT_W - 1){1'b0}}};

  logic over;
  logic [P_INT_W-1:0] low;

  assign low  = mag_i[P_INT_W-1:0];
  assign over = neg_i ? (mag_i > LIM_NEG) : (mag_i > LIM_POS);

  assign invalid_o = special_i | huge_i | over;
  assign write_o   = ~invalid_o | mask_i;
  assign inexact_o = lost_i & ~invalid_o;
  assign res_o     = invalid_o ? INDEF : (neg_i ? (~low + 1'b1) : low);

endmodule

// File: rtl/fp32_to_int32_cvt.sv
module fp32_to_int32_cvt
  import f2i_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] operand_i,
  input  logic        trunc_i,
  input  logic [1:0]  rmode_i,
  input  logic        inv_mask_i,
  output logic [31:0] result_o,
  output logic        wr_en_o,
  output logic        invalid_o,
  output logic        inexact_o,
  output logic        done_o
);

  // reset: asserted asynchronously, released through two flops
  logic rst_s1_q, rst_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  rmode_e           eff_mode;
  align_t           al;
  logic [INT_W:0]   mag;
  logic             lost;
  logic [INT_W-1:0] res_c;
  logic             write_c, invalid_c, inexact_c;

  assign eff_mode = trunc_i ? RM_ZERO : rmode_e'(rmode_i);

  f2i_align #(.P_EXP_W(EXP_W), .P_MAN_W(MAN_W), .P_INT_W(INT_W)) u_align (
    .op_i (operand_i),
    .al_o (al)
  );

  f2i_round #(.P_INT_W(INT_W)) u_round (
    .al_i   (al),
    .mode_i (eff_mode),
    .mag_o  (mag),
    .lost_o (lost)
  );

  f2i_range #(.P_INT_W(INT_W)) u_range (
    .neg_i     (al.neg),
    .special_i (al.special),
    .huge_i    (al.huge),
    .mag_i     (mag),
    .lost_i    (lost),
    .mask_i    (inv_mask_i),
    .res_o     (res_c),
    .write_o   (write_c),
    .invalid_o (invalid_c),
    .inexact_o (inexact_c)
  );

  // next-state
  logic        res_en;
  logic [31:0] res_d;
  logic        wr_d, inv_d, inx_d, done_d;

  always_comb begin
    res_en = start_i & write_c;
    res_d  = res_c;
    wr_d   = start_i & write_c;
    inv_d  = start_i ? invalid_c : invalid_o;
    inx_d  = start_i ? inexact_c : inexact_o;
    done_d = start_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      result_o <= '0;
    end else if (res_en) begin
      result_o <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      wr_en_o   <= 1'b0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      wr_en_o   <= wr_d;
      invalid_o <= inv_d;
      inexact_o <= inx_d;
      done_o    <= done_d;
    end
  end

endmodule

// File: rtl/f2i_checker.sv
module f2i_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [31:0] operand_i,
  input logic        trunc_i,
  input logic [1:0]  rmode_i,
  input logic        inv_mask_i,
  input logic [31:0] result_o,
  input logic        wr_en_o,
  input logic        invalid_o,
  input logic        inexact_o,
  input logic        done_o
);

  // R1: done follows the start strobe by one cycle
  a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  a_r1_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> done_o);

  // R4: all-ones exponent is always invalid
  a_r4_special_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && operand_i[30:23] == 8'hFF) |=> invalid_o);

  // R6: masked invalid writes the indefinite pattern
  a_r6_masked_indef: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && inv_mask_i) ##1 invalid_o |-> (wr_en_o && result_o == 32'h8000_0000));

  // R7: unmasked invalid suppresses the write and holds the result
  a_r7_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !inv_mask_i) ##1 invalid_o |-> (!wr_en_o && $stable(result_o)));

  // R8: never both flags on one conversion
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(invalid_o && inexact_o));

  // R9: zero or denormal operand never invalid
  a_r9_tiny_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && operand_i[30:23] == 8'h00) |=> (!invalid_o && wr_en_o));

endmodule

bind fp32_to_int32_cvt f2i_checker u_f2i_checker (.*);

// File: tb/test_fp32_to_int32_cvt.sv
`timescale 1ns/1ps
module test_fp32_to_int32_cvt;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic        trunc_i = 1'b0;
  logic [1:0]  rmode_i = 2'b00;
  logic        inv_mask_i = 1'b0;
  logic [31:0] result_o;
  logic        wr_en_o, invalid_o, inexact_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] last_res = '0;

  always #2.5 clk = ~clk;

  fp32_to_int32_cvt i_fp32_to_int32_cvt (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
    .trunc_i(trunc_i), .rmode_i(rmode_i), .inv_mask_i(inv_mask_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .invalid_o(invalid_o),
    .inexact_o(inexact_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s op=%h trunc=%0d mode=%0d mask=%0d actual=%h expected=%h",
               tag, operand_i, trunc_i, rmode_i, inv_mask_i, act, exp_v);
    end
  endtask

  // One conversion, compared with a real-arithmetic model.
  task automatic convert(input logic [31:0] op, input logic tr, input logic [1:0] md,
                         input logic mk, input string force_tag);
    int     e;
    real    mag, x, fr;
    longint t, r;
    bit     inv, inx;
    logic [1:0] m_eff;
    logic [31:0] exp_res;
    logic exp_wr;
    string tag;

    e = int'(op[30:23]);
    m_eff = tr ? 2'b11 : md;
    inv = 1'b0; inx = 1'b0; r = 0;
    if (e == 255) begin
      inv = 1'b1;
      tag = "R4";
    end else begin
      if (e == 0) mag = real'(op[22:0]) * (2.0 ** (-149));
      else        mag = (real'(op[22:0]) + 8388608.0) * (2.0 ** (e - 150));
      if (mag >= 2.0 ** 34) begin
        inv = 1'b1;
      end else begin
        x = op[31] ? -mag : mag;
        t = longint'(x);
        if (real'(t) > x) t = t - 1;
        fr = x - real'(t);
        case (m_eff)
          2'b00: r = (fr > 0.5) ? t + 1 : ((fr == 0.5) ? t + (t & 1) : t);
          2'b01: r = t;
          2'b10: r = (fr > 0.0) ? t + 1 : t;
          default: r = (x < 0.0 && fr > 0.0) ? t + 1 : t;
        endcase
        inv = (r > 64'sd2147483647) || (r < -64'sd2147483648);
        inx = (fr != 0.0) && !inv;
      end
      if (e == 0)      tag = "R9";
      else if (inv)    tag = "R5";
      else if (tr)     tag = "R3";
      else             tag = "R2";
    end
    if (inv) tag = {tag, mk ? "/R6" : "/R7"};
    else     tag = {tag, "/R8"};
    if (force_tag != "") tag = force_tag;

    exp_wr  = !inv || mk;
    exp_res = inv ? (mk ? 32'h8000_0000 : last_res) : r[31:0];

    @(negedge clk);
    operand_i = op; trunc_i = tr; rmode_i = md; inv_mask_i = mk; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(tag, {done_o, wr_en_o, invalid_o, result_o},
             {1'b1, exp_wr, inv, exp_res});
    chk({tag, " inexact"}, {34'b0, inexact_o}, {34'b0, inx});
    if (exp_wr) last_res = exp_res;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [22:0] PATS [8] = '{23'h000000, 23'h000001, 23'h400000, 23'h400001,
                                       23'h3FFFFF, 23'h7FFFFF, 23'h200000, 23'h600000};

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10", {result_o, wr_en_o, invalid_o, done_o}, 35'b0);
    chk("R10 inexact", {34'b0, inexact_o}, 35'b0);

    // directed boundaries
    convert(32'hCF00_0000, 1'b0, 2'b00, 1'b0, "R5 minus 2^31 legal");
    convert(32'h4F00_0000, 1'b0, 2'b00, 1'b0, "R5/R7 plus 2^31 unmasked");
    convert(32'h4F00_0000, 1'b0, 2'b00, 1'b1, "R5/R6 plus 2^31 masked");
    convert(32'h4EFF_FFFF, 1'b0, 2'b10, 1'b0, "R5 largest below 2^31");
    convert(32'hCF00_0001, 1'b1, 2'b00, 1'b1, "R5/R6 below minus 2^31");
    convert(32'h7FC0_0000, 1'b0, 2'b00, 1'b1, "R4/R6 quiet NaN");
    convert(32'h7F80_0001, 1'b0, 2'b00, 1'b0, "R4/R7 signalling NaN");
    convert(32'hFF80_0000, 1'b1, 2'b00, 1'b1, "R4/R6 minus infinity");
    convert(32'h3FC0_0000, 1'b0, 2'b00, 1'b0, "R2 1.5 nearest even");
    convert(32'h4020_0000, 1'b0, 2'b00, 1'b0, "R2 2.5 nearest even");
    convert(32'hC020_0000, 1'b1, 2'b10, 1'b0, "R3 -2.5 truncates");
    convert(32'h0000_0001, 1'b0, 2'b10, 1'b0, "R9 denormal up");
    convert(32'h8000_0001, 1'b0, 2'b01, 1'b0, "R9 negative denormal down");
    convert(32'h8000_0000, 1'b0, 2'b01, 1'b0, "R9 minus zero");

    // R1: done is a single pulse
    @(negedge clk);
    chk("R1 done drops", {34'b0, done_o}, 35'b0);
    chk("R1 no write when idle", {34'b0, wr_en_o}, 35'b0);

    // near-exhaustive sweep of exponents, signs, modes and flavours
    for (int e = 0; e < 256; e++) begin
      for (int p = 0; p < 8; p++) begin
        for (int s = 0; s < 2; s++) begin
          for (int m = 0; m < 5; m++) begin
            convert({s[0], e[7:0], PATS[p]}, (m == 4), (m == 4) ? 2'(e + p) : m[1:0],
                    e[0] ^ p[0] ^ m[0], "");
          end
        end
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule